// File: doc/BRIEF.md
# Configurable edge interrupt detector

This block watches a pair of external interrupt pins, which may change at any time, and turns each qualifying transition into a one-cycle request pulse in the system clock domain. Each pin first passes through a two-flop synchroniser. Its synchronised level is then compared with the level from the previous cycle.

A single 8-bit configuration register, which software can write and read back, sets the behaviour of each channel. A per-channel mode bit chooses between detecting one edge direction and detecting every transition. In single-edge mode, a per-channel polarity bit chooses rising or falling. In any-edge mode the polarity bit has no effect.

The request outputs go to a separate interrupt controller. Pending flags and acknowledge are handled there. After reset the detector stays quiet until its pipeline holds real pin samples, so a pin that is high during reset does not produce a request.

Top module: `edge_irq_detect`

## Requirements
- R1: The configuration register resets to 0x00. After a write cycle, all 8 bits read back on `cfg_rdata` with the written value.
- R2: Bits 3:0 are reserved. They are stored and read back like any other bit, and they have no effect on detection.
- R3: The register layout is as follows. Bit 7 is the mode bit of channel 1 and bit 6 is the mode bit of channel 0; in both, 0 means single-edge and 1 means any-edge. Bit 5 is the polarity bit of channel 1 and bit 4 is the polarity bit of channel 0.
- R4: In single-edge mode with polarity 0, a rising pin edge raises that channel's pulse and a falling edge does not. The pulse appears in the third clock cycle after the pin is sampled: the pin is sampled at edge k and the pulse is high from edge k+2 until edge k+3.
- R5: In single-edge mode with polarity 1, a falling pin edge raises the pulse and a rising edge does not. The timing is the same as in R4.
- R6: In any-edge mode, both rising and falling edges raise the pulse, whatever the polarity bit holds.
- R7: Each detected edge produces exactly one pulse, one clock cycle wide.
- R8: After reset is released, no pulse comes from the reset state of the pipeline. A pin held high through reset raises no request.
- R9: The two channels are independent. Bit 0 of `irq_line_i` and bit 0 of `irq_pulse_o` belong to channel 0, and bit 1 of each belongs to channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Value to write into the configuration register |
| cfg_rdata | output | 8 | Current configuration register value |
| irq_line_i | input | 2 | Asynchronous interrupt pins, one per channel |
| irq_pulse_o | output | 2 | One-cycle interrupt request per channel |

## Verification
A stuck or wrong register bit shows on `cfg_rdata` in the cycle after the write. It also shows as a missing or extra pulse on the next pin transition of the affected channel. A fault in the synchroniser, in the previous-level flop or in the arming logic moves the pulse away from the third cycle after sampling, stretches it, or produces a pulse right after reset. Each of these is visible within four cycles of the stimulus that exposes it.

// File: rtl/edge_irq_pkg.sv
// Shared constants and types for the edge interrupt detector.
// Assumes the channel mode and polarity fields sit in the upper nibble.
package edge_irq_pkg;
    localparam int NUM_CH   = 2;
    localparam int CFG_W    = 8;
    localparam int MODE_LSB = 6;
    localparam int POL_LSB  = 4;

    typedef enum logic {
        EDGE_SINGLE = 1'b0,
        EDGE_ANY    = 1'b1
    } edge_mode_e;
endpackage

// File: rtl/edge_irq_cfg.sv
// Configuration register: every bit can be written and read back.
// Splits out the per-channel mode and polarity fields.
// Assumes the write strobe is synchronous to clk.
module edge_irq_cfg #(
    parameter int CFG_W    = 8,
    parameter int NUM_CH   = 2,
    parameter int MODE_LSB = 6,
    parameter int POL_LSB  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output logic [NUM_CH-1:0] mode,
    output logic [NUM_CH-1:0] pol
);
    logic [CFG_W-1:0] cfg_q;

    // Hold the register; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_q <= '0;
        else if (we) cfg_q <= wdata;
    end

    assign rdata = cfg_q;
    assign mode  = cfg_q[MODE_LSB +: NUM_CH];
    assign pol   = cfg_q[POL_LSB +: NUM_CH];

    // R1: a written value is what the port shows in the next cycle
    p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == $past(wdata)));
endmodule

// File: rtl/edge_irq_sync.sv
// Multi-flop synchroniser, one chain per channel.
// Assumes the inputs are asynchronous levels; the chains reset to 0.
module edge_irq_sync #(
    parameter int NUM_CH = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] async_i,
    output logic [NUM_CH-1:0] sync_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [STAGES-1:0] chain_q;

        // Shift the pin level through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[c]};
        end

        assign sync_o[c] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/edge_irq_core.sv
// Edge comparison and mode/polarity selection with registered pulses.
// Pulses are held off until the synchroniser and the previous-level flop
// carry real samples, so the reset state never looks like an edge.
module edge_irq_core #(
    parameter int NUM_CH = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sync_i,
    input  logic [NUM_CH-1:0] mode_i,
    input  logic [NUM_CH-1:0] pol_i,
    output logic [NUM_CH-1:0] pulse_o
);
    import edge_irq_pkg::*;

    localparam int ARM_CNT = STAGES + 1;
    localparam int CNT_W   = $clog2(ARM_CNT + 1);

    logic [CNT_W-1:0]  arm_q;
    logic              armed;
    logic [NUM_CH-1:0] prev_q;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] pulse_q;

    assign armed = (arm_q == CNT_W'(ARM_CNT));

    // Count the cycles since reset until the pipeline holds real data.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_q <= '0;
        else if (!armed) arm_q <= arm_q + 1'b1;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic rise, fall;
        assign rise = sync_i[c] & ~prev_q[c];
        assign fall = ~sync_i[c] & prev_q[c];

        // Pick the qualifying transition from the mode and polarity bits.
        always_comb begin
            if (edge_mode_e'(mode_i[c]) == EDGE_ANY) hit[c] = rise | fall;
            else if (pol_i[c])                        hit[c] = fall;
            else                                      hit[c] = rise;
        end

        // R4: with the rising edge selected, a pulse follows a rising synchronised level
        p_rise_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_q[c] && !$past(mode_i[c]) && !$past(pol_i[c])) |->
                ($past(sync_i[c]) && !$past(prev_q[c])));

        // R5: with the falling edge selected, a pulse follows a falling synchronised level
        p_fall_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_q[c] && !$past(mode_i[c]) && $past(pol_i[c])) |->
                (!$past(sync_i[c]) && $past(prev_q[c])));

        // R6: any change of level in any-edge mode after arming gives a pulse
        p_any_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(armed) && $past(mode_i[c]) &&
             ($past(sync_i[c]) != $past(prev_q[c]))) |-> pulse_q[c]);
    end

    // Keep the previous level, and register the pulses once armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            pulse_q <= '0;
        end else begin
            prev_q  <= sync_i;
            pulse_q <= armed ? hit : '0;
        end
    end

    assign pulse_o = pulse_q;

    // R8: no pulse before the pipeline is filled with real samples
    p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(armed) |-> (pulse_q == '0));
endmodule

// File: rtl/edge_irq_detect.sv
// Top level of the two-channel configurable edge interrupt detector.
// Pins are asynchronous. Register access and outputs are in the clk domain.
module edge_irq_detect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic [1:0] irq_line_i,
    output logic [1:0] irq_pulse_o
);
    import edge_irq_pkg::*;

    localparam int SYNC_STAGES = 2;

    logic [NUM_CH-1:0] mode, pol, synced;

    edge_irq_cfg #(
        .CFG_W(CFG_W), .NUM_CH(NUM_CH), .MODE_LSB(MODE_LSB), .POL_LSB(POL_LSB)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .mode(mode), .pol(pol)
    );

    edge_irq_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(irq_line_i), .sync_o(synced)
    );

    edge_irq_core #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_core (
        .clk(clk), .rst_n(rst_n), .sync_i(synced), .mode_i(mode),
        .pol_i(pol), .pulse_o(irq_pulse_o)
    );
endmodule

// File: tb/sim_edge_irq_detect.sv
`timescale 1ns/1ps
module sim_edge_irq_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [1:0] irq_line_i = 2'b00;
    logic [1:0] irq_pulse_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    edge_irq_detect u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_line_i(irq_line_i), .irq_pulse_o(irq_pulse_o)
    );

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_cfg(logic [7:0] v, string req);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        check8(req, cfg_rdata, v);
    endtask

    // Drive the pins, then expect the pulse only in the third cycle after sampling.
    task automatic edge_step(logic [1:0] pins, logic [1:0] exp, string req);
        @(negedge clk);
        irq_line_i = pins;
        @(posedge clk); #1 check8({req, " cyc0"}, {6'b0, irq_pulse_o}, 8'h00);
        @(posedge clk); #1 check8({req, " cyc1"}, {6'b0, irq_pulse_o}, 8'h00);
        @(posedge clk); #1 check8({req, " cyc2"}, {6'b0, irq_pulse_o}, {6'b0, exp});
        @(posedge clk); #1 check8({req, " R7 width"}, {6'b0, irq_pulse_o}, 8'h00);
    endtask

    task automatic t_reset;
        irq_line_i = 2'b01;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check8("R1 reset value", cfg_rdata, 8'h00);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1 check8("R8 quiet after reset", {6'b0, irq_pulse_o}, 8'h00);
        end
    endtask

    task automatic t_readback;
        write_cfg(8'hA5, "R1 readback A5");
        write_cfg(8'h5A, "R1 readback 5A");
        write_cfg(8'h00, "R1 readback 00");
    endtask

    task automatic t_rising;
        write_cfg(8'h00, "R3 rising cfg");
        edge_step(2'b00, 2'b00, "R4 fall ignored ch0");
        edge_step(2'b01, 2'b01, "R4 rise ch0");
        edge_step(2'b00, 2'b00, "R4 fall ignored ch0 again");
        edge_step(2'b10, 2'b10, "R4 rise ch1");
        edge_step(2'b00, 2'b00, "R4 fall ignored ch1");
    endtask

    task automatic t_falling;
        write_cfg(8'h30, "R3 falling cfg");
        edge_step(2'b01, 2'b00, "R5 rise ignored ch0");
        edge_step(2'b00, 2'b01, "R5 fall ch0");
        edge_step(2'b10, 2'b00, "R5 rise ignored ch1");
        edge_step(2'b00, 2'b10, "R5 fall ch1");
    endtask

    task automatic t_any;
        write_cfg(8'hC0, "R3 any-edge cfg");
        edge_step(2'b01, 2'b01, "R6 rise ch0 pol0");
        edge_step(2'b00, 2'b01, "R6 fall ch0 pol0");
        write_cfg(8'hF0, "R3 any-edge pol1 cfg");
        edge_step(2'b11, 2'b11, "R6 rise both pol1");
        edge_step(2'b00, 2'b11, "R6 fall both pol1");
    endtask

    task automatic t_independent;
        write_cfg(8'h80, "R9 mixed cfg");
        edge_step(2'b11, 2'b11, "R9 rise both");
        edge_step(2'b00, 2'b10, "R9 fall only ch1");
    endtask

    task automatic t_reserved;
        write_cfg(8'h0F, "R2 reserved readback");
        edge_step(2'b01, 2'b01, "R2 rise ch0 unaffected");
        edge_step(2'b00, 2'b00, "R2 fall ch0 unaffected");
        edge_step(2'b10, 2'b10, "R2 rise ch1 unaffected");
        edge_step(2'b00, 2'b00, "R2 fall ch1 unaffected");
    endtask

    initial begin
        t_reset();
        t_readback();
        t_rising();
        t_falling();
        t_any();
        t_independent();
        t_reserved();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule